// File: doc/BRIEF.md
# I2C Target Controller with Write-One-to-Clear Status

This block lets a host processor act as a 7-bit-addressed target on an I2C bus. It watches SCL and SDA, recognises its own address in the first byte after a START, acknowledges it, and then moves data one byte at a time in the direction the bus controller asked for. Every data byte is started by a software handshake. While the host has not yet given the go-ahead, the block holds SCL low. This lets firmware take as long as it needs to supply or consume each byte.

The host sees four byte-wide registers through a simple write-strobe and combinational-read port. Offset 0 is control: bit 0 is the byte go-ahead, and bits 7:4 enable the four interrupt sources. Offset 1 is status. Offset 2 is the single data buffer, shared by both directions. Offset 3 holds the own address in bits 6:0. Event flags in the status register stay set until the host clears them. A level interrupt is raised while any enabled flag is set. The pins are open-drain: each output asks for its line to be pulled low, and otherwise leaves the line released.

Top module: `i2c_slave_ctl`

## Requirements
- R1: After reset, status (offset 1), control (offset 0) and data (offset 2) read 0x00, offset 3 reads the RESET_ADDR parameter, `irq` is 0, and neither `scl_oe` nor `sda_oe` is asserted.
- R2: When the first byte after a START carries the own address in its upper seven bits, the block drives SDA low during the ninth clock. It then sets status bit 0 (address seen) and bit 4 (busy), and copies the byte's lowest bit into status bit 5 (1 = the bus controller reads).
- R3: A first byte whose upper seven bits differ from the own address gets no acknowledge, sets no status bit and causes no clock stretching.
- R4: Status bits 3:0 are cleared only by a host write to offset 1 with a 1 in that bit position. Writing 0 leaves the bit unchanged.
- R5: After the address acknowledge, and after every data byte that does not end the transfer, `scl_oe` holds SCL low until the host writes 1 to control bit 0. That bit then clears itself once the byte has started.
- R6: In a bus write, the eight received bits (MSB first) land in the data register, status bit 2 (receive full) is set, and the block acknowledges the byte.
- R7: In a bus read, the data register is shifted out MSB first. Status bit 1 (transmit empty) is set once the ninth clock of the byte has risen.
- R8: Status bit 6 holds the SDA level the bus controller gave in the ninth clock of the last transmitted byte (1 = NACK). After a NACK the block releases both lines and does not stretch.
- R9: A STOP (SDA rising while SCL is high) clears busy. If the block was busy, it also sets status bit 3 (stop seen). A STOP on a transfer addressed elsewhere sets nothing.
- R10: `irq` is 1 exactly while some status bit n (n = 0..3) and its control enable bit n+4 are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; SCL and SDA are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 2 | Register offset for read and write |
| reg_we | input | 1 | Write strobe for the addressed register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data of the addressed register |
| irq | output | 1 | Level interrupt request |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe | output | 1 | 1 pulls SCL low (stretching) |
| sda_oe | output | 1 | 1 pulls SDA low (acknowledge or data 0) |

## Verification
The bench builds the block with SYNC_STAGES=3 and RESET_ADDR=0x2C and then moves the own address to 0x51 from software. The longer synchroniser adds a cycle of lag between the bus and the state machine, so the stretch hand-off and the acknowledge timing are checked with less slack than the default gives. The reset address is left as a stale value on purpose: a START addressed to 0x2C must then be rejected, which shows the address register really steers the match. The bus controller model runs at twelve system clocks per half bit and waits for SCL to rise, so it only makes progress when the stretching releases correctly.

// File: rtl/i2c_slv_pkg.sv
`timescale 1ns/1ps
package i2c_slv_pkg;

   localparam int NFLAG = 4;

   localparam logic [1:0] REG_CTRL = 2'd0;
   localparam logic [1:0] REG_STAT = 2'd1;
   localparam logic [1:0] REG_DATA = 2'd2;
   localparam logic [1:0] REG_OWN  = 2'd3;

   localparam int CTRL_GO     = 0;
   localparam int CTRL_EN_LSB = 4;

   localparam int FLG_ADDR = 0;
   localparam int FLG_TXE  = 1;
   localparam int FLG_RXF  = 2;
   localparam int FLG_STOP = 3;
   localparam int ST_BUSY  = 4;
   localparam int ST_RNW   = 5;
   localparam int ST_NACK  = 6;

   typedef enum logic [3:0] {
      E_IDLE,
      E_ADDR,
      E_ADDR_END,
      E_ADDR_ACK,
      E_RX_HOLD,
      E_RX_BITS,
      E_RX_END,
      E_RX_ACK,
      E_TX_HOLD,
      E_TX_BITS,
      E_TX_ACK
   } eng_st_t;

endpackage

// File: rtl/i2c_slv_sync.sv
`timescale 1ns/1ps
module i2c_slv_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_ev,
   output logic stop_ev
);

   if (STAGES < 2) begin : g_bad_stages
      $error("i2c_slv_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] scl_chain;
   logic [STAGES-1:0] sda_chain;
   logic              scl_p;
   logic              sda_p;
   logic              scl_s;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_chain <= '1;
         sda_chain <= '1;
         scl_p     <= 1'b1;
         sda_p     <= 1'b1;
      end else begin
         scl_chain <= {scl_chain[STAGES-2:0], scl_i};
         sda_chain <= {sda_chain[STAGES-2:0], sda_i};
         scl_p     <= scl_chain[STAGES-1];
         sda_p     <= sda_chain[STAGES-1];
      end
   end

   assign scl_s    = scl_chain[STAGES-1];
   assign sda_s    = sda_chain[STAGES-1];
   assign scl_rise = scl_s & ~scl_p;
   assign scl_fall = ~scl_s & scl_p;
   assign start_ev = scl_s & scl_p & sda_p & ~sda_s;
   assign stop_ev  = scl_s & scl_p & ~sda_p & sda_s;

endmodule

// File: rtl/i2c_slv_engine.sv
`timescale 1ns/1ps
module i2c_slv_engine
   import i2c_slv_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sda_s,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              start_ev,
   input  logic              stop_ev,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              go_req,
   input  logic [DATA_W-1:0] tx_byte,
   output logic              scl_pull,
   output logic              sda_pull,
   output logic              go_take,
   output logic              ev_addr,
   output logic              ev_txe,
   output logic              ev_rxf,
   output logic              ev_stop,
   output logic [DATA_W-1:0] rx_byte,
   output logic              busy,
   output logic              rnw,
   output logic              nack
);

   localparam int CNT_W = $clog2(DATA_W);
   localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

   if (ADDR_W != DATA_W - 1) begin : g_bad_width
      $error("i2c_slv_engine: ADDR_W must be DATA_W-1");
   end

   eng_st_t           st;
   logic [DATA_W-1:0] sh;
   logic [CNT_W-1:0]  cnt;
   logic              busy_q;
   logic              rnw_q;
   logic              nack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= E_IDLE;
         sh      <= '0;
         cnt     <= '0;
         busy_q  <= 1'b0;
         rnw_q   <= 1'b0;
         nack_q  <= 1'b0;
         go_take <= 1'b0;
         ev_addr <= 1'b0;
         ev_txe  <= 1'b0;
         ev_rxf  <= 1'b0;
         ev_stop <= 1'b0;
      end else begin
         go_take <= 1'b0;
         ev_addr <= 1'b0;
         ev_txe  <= 1'b0;
         ev_rxf  <= 1'b0;
         ev_stop <= 1'b0;
         if (stop_ev) begin
            ev_stop <= busy_q;
            busy_q  <= 1'b0;
            st      <= E_IDLE;
         end else if (start_ev) begin
            st  <= E_ADDR;
            cnt <= '0;
         end else begin
            case (st)
               E_ADDR: if (scl_rise) begin
                  sh <= {sh[DATA_W-2:0], sda_s};
                  if (cnt == LAST_BIT) st <= E_ADDR_END;
                  else                 cnt <= cnt + 1'b1;
               end
               E_ADDR_END: if (scl_fall) begin
                  if (sh[DATA_W-1:1] == own_addr) begin
                     st      <= E_ADDR_ACK;
                     busy_q  <= 1'b1;
                     rnw_q   <= sh[0];
                     nack_q  <= 1'b0;
                     ev_addr <= 1'b1;
                  end else begin
                     st <= E_IDLE;
                  end
               end
               E_ADDR_ACK: if (scl_fall) st <= rnw_q ? E_TX_HOLD : E_RX_HOLD;
               E_RX_HOLD: if (go_req) begin
                  st      <= E_RX_BITS;
                  cnt     <= '0;
                  go_take <= 1'b1;
               end
               E_RX_BITS: if (scl_rise) begin
                  sh <= {sh[DATA_W-2:0], sda_s};
                  if (cnt == LAST_BIT) st <= E_RX_END;
                  else                 cnt <= cnt + 1'b1;
               end
               E_RX_END: if (scl_fall) begin
                  ev_rxf <= 1'b1;
                  st     <= E_RX_ACK;
               end
               E_RX_ACK: if (scl_fall) st <= E_RX_HOLD;
               E_TX_HOLD: if (go_req) begin
                  sh      <= tx_byte;
                  cnt     <= '0;
                  st      <= E_TX_BITS;
                  go_take <= 1'b1;
               end
               E_TX_BITS: if (scl_fall) begin
                  if (cnt == LAST_BIT) begin
                     st <= E_TX_ACK;
                  end else begin
                     sh  <= {sh[DATA_W-2:0], 1'b0};
                     cnt <= cnt + 1'b1;
                  end
               end
               E_TX_ACK: begin
                  if (scl_rise) begin
                     nack_q <= sda_s;
                     ev_txe <= 1'b1;
                  end
                  if (scl_fall) st <= nack_q ? E_IDLE : E_TX_HOLD;
               end
               default: st <= E_IDLE;
            endcase
         end
      end
   end

   always_comb begin
      case (st)
         E_ADDR_ACK, E_RX_ACK: sda_pull = 1'b1;
         E_TX_BITS:            sda_pull = ~sh[DATA_W-1];
         default:              sda_pull = 1'b0;
      endcase
   end

   assign scl_pull = (st == E_RX_HOLD) || (st == E_TX_HOLD);
   assign rx_byte  = sh;
   assign busy     = busy_q;
   assign rnw      = rnw_q;
   assign nack     = nack_q;

endmodule

// File: rtl/i2c_slv_regs.sv
`timescale 1ns/1ps
module i2c_slv_regs
   import i2c_slv_pkg::*;
#(
   parameter int              DATA_W     = 8,
   parameter int              ADDR_W     = 7,
   parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NFLAG-1:0]  ev_flags,
   input  logic              busy,
   input  logic              rnw,
   input  logic              nack,
   input  logic [DATA_W-1:0] rx_byte,
   input  logic              go_take,
   output logic              go_req,
   output logic [DATA_W-1:0] buf_byte,
   output logic [ADDR_W-1:0] own_addr,
   output logic [NFLAG-1:0]  flag_q,
   output logic              irq
);

   if (DATA_W < CTRL_EN_LSB + NFLAG) begin : g_bad_data_w
      $error("i2c_slv_regs: DATA_W too narrow for the control layout");
   end

   logic [NFLAG-1:0] en_q;
   logic             wr_ctrl;
   logic             wr_stat;
   logic             wr_data;
   logic             wr_own;

   assign wr_ctrl = reg_we && (reg_addr == REG_CTRL);
   assign wr_stat = reg_we && (reg_addr == REG_STAT);
   assign wr_data = reg_we && (reg_addr == REG_DATA);
   assign wr_own  = reg_we && (reg_addr == REG_OWN);

   for (genvar g = 0; g < NFLAG; g++) begin : g_flag
      logic f;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                        f <= 1'b0;
         else if (ev_flags[g])              f <= 1'b1;
         else if (wr_stat && reg_wdata[g])  f <= 1'b0;
      end
      assign flag_q[g] = f;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         go_req   <= 1'b0;
         en_q     <= '0;
         buf_byte <= '0;
         own_addr <= RESET_ADDR;
      end else begin
         if (wr_ctrl) begin
            go_req <= reg_wdata[CTRL_GO];
            en_q   <= reg_wdata[CTRL_EN_LSB +: NFLAG];
         end else if (go_take) begin
            go_req <= 1'b0;
         end
         if (ev_flags[FLG_RXF]) buf_byte <= rx_byte;
         else if (wr_data)      buf_byte <= reg_wdata;
         if (wr_own) own_addr <= reg_wdata[ADDR_W-1:0];
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         REG_CTRL: begin
            reg_rdata[CTRL_GO]                = go_req;
            reg_rdata[CTRL_EN_LSB +: NFLAG]   = en_q;
         end
         REG_STAT: begin
            reg_rdata[NFLAG-1:0] = flag_q;
            reg_rdata[ST_BUSY]   = busy;
            reg_rdata[ST_RNW]    = rnw;
            reg_rdata[ST_NACK]   = nack;
         end
         REG_DATA: reg_rdata = buf_byte;
         default:  reg_rdata[ADDR_W-1:0] = own_addr;
      endcase
   end

   assign irq = |(flag_q & en_q);

endmodule

// File: rtl/i2c_slave_ctl.sv
`timescale 1ns/1ps
module i2c_slave_ctl
   import i2c_slv_pkg::*;
#(
   parameter int                DATA_W      = 8,
   parameter int                ADDR_W      = 7,
   parameter int                SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0] RESET_ADDR  = 7'h50
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        reg_addr,
   input  logic              reg_we,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe
);

   logic              sda_s;
   logic              scl_rise;
   logic              scl_fall;
   logic              start_ev;
   logic              stop_ev;
   logic              ev_addr;
   logic              ev_txe;
   logic              ev_rxf;
   logic              ev_stop;
   logic              eng_busy;
   logic              eng_rnw;
   logic              eng_nack;
   logic              xfer_req;
   logic              xfer_take;
   logic [DATA_W-1:0] rx_byte;
   logic [DATA_W-1:0] buf_byte;
   logic [ADDR_W-1:0] own_addr;
   logic [NFLAG-1:0]  flag_q;
   logic [NFLAG-1:0]  ev_flags;

   i2c_slv_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk      (clk),
      .rst_n    (rst_n),
      .scl_i    (scl_i),
      .sda_i    (sda_i),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev)
   );

   i2c_slv_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_eng (
      .clk      (clk),
      .rst_n    (rst_n),
      .sda_s    (sda_s),
      .scl_rise (scl_rise),
      .scl_fall (scl_fall),
      .start_ev (start_ev),
      .stop_ev  (stop_ev),
      .own_addr (own_addr),
      .go_req   (xfer_req),
      .tx_byte  (buf_byte),
      .scl_pull (scl_oe),
      .sda_pull (sda_oe),
      .go_take  (xfer_take),
      .ev_addr  (ev_addr),
      .ev_txe   (ev_txe),
      .ev_rxf   (ev_rxf),
      .ev_stop  (ev_stop),
      .rx_byte  (rx_byte),
      .busy     (eng_busy),
      .rnw      (eng_rnw),
      .nack     (eng_nack)
   );

   always_comb begin
      ev_flags           = '0;
      ev_flags[FLG_ADDR] = ev_addr;
      ev_flags[FLG_TXE]  = ev_txe;
      ev_flags[FLG_RXF]  = ev_rxf;
      ev_flags[FLG_STOP] = ev_stop;
   end

   i2c_slv_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RESET_ADDR(RESET_ADDR)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .ev_flags  (ev_flags),
      .busy      (eng_busy),
      .rnw       (eng_rnw),
      .nack      (eng_nack),
      .rx_byte   (rx_byte),
      .go_take   (xfer_take),
      .go_req    (xfer_req),
      .buf_byte  (buf_byte),
      .own_addr  (own_addr),
      .flag_q    (flag_q),
      .irq       (irq)
   );

endmodule

// File: rtl/i2c_slave_chk.sv
`timescale 1ns/1ps
module i2c_slave_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              irq,
   input logic [3:0]        flags,
   input logic              busy,
   input logic              scl_oe,
   input logic              ev_addr,
   input logic              ev_stop,
   input logic              xfer_q,
   input logic              xfer_take,
   input logic              reg_we,
   input logic [1:0]        reg_addr,
   input logic [DATA_W-1:0] reg_wdata
);

   p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (flags != 4'b0));

   p_addr_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ev_addr |=> (flags[0] && busy));

   p_stop_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ev_stop |=> (flags[3] && !busy));

   p_idle_no_stretch_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !scl_oe);

   p_go_selfclear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_take && !(reg_we && reg_addr == 2'd0)) |=> !xfer_q);

   p_w1c_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[3] && !(reg_we && reg_addr == 2'd1 && reg_wdata[3])) |=> flags[3]);

endmodule

bind i2c_slave_ctl i2c_slave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .flags     (flag_q),
   .busy      (eng_busy),
   .scl_oe    (scl_oe),
   .ev_addr   (ev_addr),
   .ev_stop   (ev_stop),
   .xfer_q    (xfer_req),
   .xfer_take (xfer_take),
   .reg_we    (reg_we),
   .reg_addr  (reg_addr),
   .reg_wdata (reg_wdata)
);

// File: tb/test_i2c_slave_ctl.sv
`timescale 1ns/1ps
module test_i2c_slave_ctl;

   localparam int HP = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] reg_addr = 2'd0;
   logic       reg_we = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       irq;
   logic       scl_oe;
   logic       sda_oe;
   logic       m_scl_low = 1'b0;
   logic       m_sda_low = 1'b0;
   logic       scl_line;
   logic       sda_line;

   int total = 0;
   int bad   = 0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic [7:0] got_q[$];

   always #10 clk = ~clk;

   assign scl_line = !(m_scl_low || scl_oe);
   assign sda_line = !(m_sda_low || sda_oe);

   i2c_slave_ctl #(.DATA_W(8), .ADDR_W(7), .SYNC_STAGES(3), .RESET_ADDR(7'h2C)) i_i2c_slave_ctl (
      .clk       (clk),
      .rst_n     (rst_n),
      .reg_addr  (reg_addr),
      .reg_we    (reg_we),
      .reg_wdata (reg_wdata),
      .reg_rdata (reg_rdata),
      .irq       (irq),
      .scl_i     (scl_line),
      .sda_i     (sda_line),
      .scl_oe    (scl_oe),
      .sda_oe    (sda_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input logic [1:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic reg_rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_clks(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic m_clock(output logic s);
      m_scl_low = 1'b0;
      wait (scl_line == 1'b1);
      wait_clks(HP / 2);
      s = sda_line;
      wait_clks(HP / 2);
      m_scl_low = 1'b1;
      wait_clks(HP);
   endtask

   task automatic m_start;
      m_sda_low = 1'b1;
      wait_clks(HP);
      m_scl_low = 1'b1;
      wait_clks(HP);
   endtask

   task automatic m_stop;
      m_sda_low = 1'b1;
      wait_clks(4);
      m_scl_low = 1'b0;
      wait (scl_line == 1'b1);
      wait_clks(HP);
      m_sda_low = 1'b0;
      wait_clks(HP);
   endtask

   task automatic m_send(input logic [7:0] b, output logic acked);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         m_sda_low = !b[i];
         m_clock(s);
      end
      m_sda_low = 1'b0;
      m_clock(s);
      acked = !s;
   endtask

   task automatic m_recv(input logic give_ack, output logic [7:0] b);
      logic s;
      m_sda_low = 1'b0;
      for (int i = 7; i >= 0; i--) begin
         m_clock(s);
         b[i] = s;
      end
      m_sda_low = give_ack;
      m_clock(s);
      m_sda_low = 1'b0;
   endtask

   task automatic expect_byte(input logic [7:0] b, input string tag);
      exp_q.push_back(b);
      tag_q.push_back(tag);
   endtask

   task automatic summary;
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   // scoreboard monitor: compares every observed data byte with the queued expectation
   initial begin
      forever begin
         @(negedge clk);
         while (got_q.size() != 0) begin
            logic [7:0] g;
            g = got_q.pop_front();
            if (exp_q.size() == 0) begin
               chk("R6 R7 unexpected byte", {24'h0, g}, 32'hFFFF_FFFF);
            end else begin
               string t;
               t = tag_q.pop_front();
               chk(t, {24'h0, g}, {24'h0, exp_q.pop_front()});
            end
         end
      end
   end

   initial begin
      wait_clks(100000);
      total++; bad++;
      $display("FAIL R5 watchdog: bus hung act=running exp=finished");
      summary();
      $finish;
   end

   initial begin
      logic [7:0] d;
      logic       ak;
      wait_clks(5);
      rst_n = 1'b1;
      wait_clks(2);

      // R1 reset state
      reg_rd(2'd1, d); chk("R1 status", d, 8'h00);
      reg_rd(2'd0, d); chk("R1 control", d, 8'h00);
      reg_rd(2'd2, d); chk("R1 data", d, 8'h00);
      reg_rd(2'd3, d); chk("R1 own address", d, 8'h2C);
      chk("R1 irq", irq, 1'b0);
      chk("R1 pins", {scl_oe, sda_oe}, 2'b00);

      reg_wr(2'd3, 8'h51);
      reg_wr(2'd0, 8'hF0);

      // bus write of two bytes
      m_start;
      m_send({7'h51, 1'b0}, ak); chk("R2 address ack", ak, 1'b1);
      wait_clks(20);
      chk("R5 stretch after address", scl_oe, 1'b1);
      reg_rd(2'd1, d); chk("R2 status after match", d, 8'h11);
      chk("R10 irq on enabled flag", irq, 1'b1);
      reg_wr(2'd1, 8'h00);
      reg_rd(2'd1, d); chk("R4 write 0 keeps flag", d, 8'h11);
      reg_wr(2'd1, 8'h01);
      reg_rd(2'd1, d); chk("R4 write 1 clears flag", d, 8'h10);
      chk("R10 irq drops", irq, 1'b0);

      expect_byte(8'hA5, "R6 first received byte");
      reg_wr(2'd0, 8'hF1);
      wait_clks(3);
      chk("R5 stretch released", scl_oe, 1'b0);
      reg_rd(2'd0, d); chk("R5 go bit self-clears", d, 8'hF0);
      m_send(8'hA5, ak); chk("R6 data ack", ak, 1'b1);
      wait_clks(20);
      chk("R5 stretch after data byte", scl_oe, 1'b1);
      reg_rd(2'd1, d); chk("R6 receive full", d, 8'h14);
      reg_rd(2'd2, d); got_q.push_back(d);
      reg_wr(2'd1, 8'h04);

      expect_byte(8'h3C, "R6 second received byte");
      reg_wr(2'd0, 8'hF1);
      m_send(8'h3C, ak); chk("R6 second ack", ak, 1'b1);
      reg_rd(2'd2, d); got_q.push_back(d);
      reg_wr(2'd1, 8'h04);
      reg_wr(2'd0, 8'hF1);
      m_stop;
      reg_rd(2'd1, d); chk("R9 stop flag and busy clear", d, 8'h08);
      chk("R10 irq on stop", irq, 1'b1);
      reg_wr(2'd1, 8'h08);

      // bus read of two bytes, interrupt enables masked first
      reg_wr(2'd0, 8'h00);
      m_start;
      m_send({7'h51, 1'b1}, ak); chk("R2 read address ack", ak, 1'b1);
      reg_rd(2'd1, d); chk("R2 direction bit", d, 8'h31);
      chk("R10 irq masked", irq, 1'b0);
      reg_wr(2'd0, 8'h10);
      chk("R10 irq unmasked", irq, 1'b1);
      reg_wr(2'd1, 8'h01);

      reg_wr(2'd2, 8'h96);
      expect_byte(8'h96, "R7 first sent byte");
      reg_wr(2'd0, 8'h11);
      m_recv(1'b1, d); got_q.push_back(d);
      wait_clks(10);
      chk("R5 stretch after acked send", scl_oe, 1'b1);
      reg_rd(2'd1, d); chk("R7 transmit empty, R8 ack", d, 8'h32);
      reg_wr(2'd1, 8'h02);

      reg_wr(2'd2, 8'h4B);
      expect_byte(8'h4B, "R7 second sent byte");
      reg_wr(2'd0, 8'h11);
      m_recv(1'b0, d); got_q.push_back(d);
      wait_clks(10);
      chk("R8 lines released after nack", {scl_oe, sda_oe}, 2'b00);
      reg_rd(2'd1, d); chk("R8 nack captured", d, 8'h72);
      reg_wr(2'd1, 8'h02);
      m_stop;
      reg_rd(2'd1, d); chk("R9 stop after read", d, 8'h68);
      reg_wr(2'd1, 8'h08);

      // stale reset address no longer matches
      m_start;
      m_send({7'h2C, 1'b0}, ak); chk("R3 no ack on mismatch", ak, 1'b0);
      chk("R3 no stretch on mismatch", scl_oe, 1'b0);
      reg_rd(2'd1, d); chk("R3 no flag on mismatch", d, 8'h60);
      m_stop;
      reg_rd(2'd1, d); chk("R9 no stop flag when not addressed", d, 8'h60);

      wait_clks(10);
      chk("R7 scoreboard drained", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule